// File: doc/BRIEF.md
# Wang Tile Edge Color Hasher

This block turns the integer column and row of one tile in a virtual tiled texture into the four edge colors of the tile that belongs there. It uses nested lookups into a small loadable permutation table, in the style of a discrete cat map, and wraps coordinates and table indices around a torus. Because each tile is computed from its own coordinates alone, tiles can be requested in any order. Two tiles that share an edge still receive the same color on it, which keeps the texture pattern continuous across every seam.

A request is a one-cycle start strobe carrying a tile column and row. The block then reads its single-port table once per cycle. It reuses the two inner lookups (the column hash and the doubled-row hash), so six reads reach the table instead of eight. A one-cycle done strobe marks the cycle in which all four colors are valid. Software or a preceding unit fills the table through a simple write port while the block is idle. The grid size in tiles (`COLS` x `ROWS`) and the color counts for horizontal edges (`HK`) and vertical edges (`VK`) are compile-time parameters. The table holds `max(COLS, ROWS)` entries.

Top module: `wth_edge_hasher`

## Requirements
- R1: While reset is asserted and after it is released with no request made, `done_o` is low.
- R2: A start sampled in the idle state at rising edge k makes `done_o` high for exactly one cycle, the cycle that follows rising edge k+6; the four colors are valid in that cycle.
- R3: The column is reduced modulo `COLS` and the row modulo `ROWS` (an input value at or above the grid size has the grid size subtracted). Every table index is reduced modulo the table size N = max(`COLS`,`ROWS`).
- R4: With T the table, c the reduced column and r the reduced row, south = T[(T[c] + r) mod N] mod `HK`.
- R5: north = T[(T[c] + ((r+1) mod `ROWS`)) mod N] mod `HK`.
- R6: east = T[(((c+1) mod `COLS`) + T[(2r) mod N]) mod N] mod `VK`.
- R7: west = T[(c + T[(2r) mod N]) mod N] mod `VK`.
- R8: For every tile, east of (c,r) equals west of ((c+1) mod `COLS`, r), and north of (c,r) equals south of (c, (r+1) mod `ROWS`), including across the grid wrap.
- R9: A start that arrives while a request is in progress is ignored. It changes neither the result nor the timing of the request in progress.
- R10: A table write (`tw_en_i` high at a rising edge) takes effect only when the block is idle at that edge. A write made while busy is dropped. A write at the same edge as an accepted start is already seen by that request.
- R11: Colors are plain binary numbers, 0 to `HK`-1 on south and north and 0 to `VK`-1 on east and west.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request strobe, sampled only when idle |
| col_i | input | clog2(COLS) | Tile column of the request |
| row_i | input | clog2(ROWS) | Tile row of the request |
| tw_en_i | input | 1 | Table write enable |
| tw_addr_i | input | clog2(N) | Table write index (indices at or above N are dropped) |
| tw_data_i | input | clog2(N) | Table write value |
| done_o | output | 1 | One-cycle pulse when the colors are valid |
| south_o | output | clog2(HK) | South edge color |
| east_o | output | clog2(VK) | East edge color |
| north_o | output | clog2(HK) | North edge color |
| west_o | output | clog2(VK) | West edge color |

## Verification
The hash is tried with two different permutations, each in a full sweep over every tile of a 5x4 grid. The sweeps separate errors in each of the four nested index formulas and confirm that neighbouring tiles agree on their shared edges, both inside the grid and across its wrap. Columns above the grid size are compared against their wrapped equivalents to isolate the coordinate reduction. Starts and table writes issued mid-request, a write coinciding with a start, and a start in the done cycle itself separate a correct idle-only gate from one that leaks, stalls or accepts too early.

// File: rtl/wth_pkg.sv
package wth_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_RD_S,
    ST_RD_N,
    ST_RD_E,
    ST_RD_W
  } wth_state_e;

  function automatic int unsigned wth_bits(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

  function automatic int unsigned wth_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wth_mod_add.sv
module wth_mod_add #(
  parameter int unsigned W   = 3,
  parameter int unsigned MOD = 5
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam logic [W:0] MODV = (W+1)'(MOD);

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    if (sum >= MODV) y_o = W'(sum - MODV);
    else             y_o = W'(sum);
  end
endmodule

// File: rtl/wth_color_fold.sv
module wth_color_fold #(
  parameter int unsigned W  = 3,
  parameter int unsigned K  = 3,
  parameter int unsigned KW = 2
) (
  input  logic [W-1:0]  x_i,
  output logic [KW-1:0] y_o
);
  int unsigned xi;

  always_comb begin
    xi  = 32'(x_i);
    y_o = KW'(xi % K);
  end
endmodule

// File: rtl/wth_table.sv
module wth_table #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [IW-1:0] rdata_o
);
  localparam logic [IW:0] NV = (IW+1)'(N);

  logic [IW-1:0] mem [N];
  logic          wr_ok;

  assign wr_ok = we_i && ({1'b0, waddr_i} < NV);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr_i] <= wdata_i;
  end

  always_comb begin
    if ({1'b0, raddr_i} < NV) rdata_o = mem[raddr_i];
    else                      rdata_o = '0;
  end
endmodule

// File: rtl/wth_edge_hasher.sv
module wth_edge_hasher
  import wth_pkg::*;
#(
  parameter int unsigned COLS = 5,
  parameter int unsigned ROWS = 4,
  parameter int unsigned HK   = 3,
  parameter int unsigned VK   = 2,
  localparam int unsigned NTAB = wth_max(COLS, ROWS),
  localparam int unsigned IW   = wth_bits(NTAB),
  localparam int unsigned CW   = wth_bits(COLS),
  localparam int unsigned RW   = wth_bits(ROWS),
  localparam int unsigned HW   = wth_bits(HK),
  localparam int unsigned VW   = wth_bits(VK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] col_i,
  input  logic [RW-1:0] row_i,
  input  logic          tw_en_i,
  input  logic [IW-1:0] tw_addr_i,
  input  logic [IW-1:0] tw_data_i,
  output logic          done_o,
  output logic [HW-1:0] south_o,
  output logic [VW-1:0] east_o,
  output logic [HW-1:0] north_o,
  output logic [VW-1:0] west_o
);

  wth_state_e    st_q, st_d;
  logic [CW-1:0] oh_q, oh_in, oh_nx;
  logic [RW-1:0] ov_q, ov_in, ov_nx;
  logic [IW-1:0] a_q, b_q;
  logic [HW-1:0] s_q, n_q;
  logic [VW-1:0] e_q, w_q;
  logic          done_q, done_d;

  logic          idle, cap_en, tab_we;
  logic          ld_a, ld_b, ld_s, ld_n, ld_e, ld_w;
  logic [IW-1:0] op_a, op_b, rd_idx, rd_data;
  logic [HW-1:0] rd_h;
  logic [VW-1:0] rd_v;

  // coordinate wrap of the incoming request
  wth_mod_add #(.W(CW), .MOD(COLS)) u_col_wrap (.a_i(col_i), .b_i('0), .y_o(oh_in));
  wth_mod_add #(.W(RW), .MOD(ROWS)) u_row_wrap (.a_i(row_i), .b_i('0), .y_o(ov_in));

  // neighbour coordinates on the torus
  wth_mod_add #(.W(CW), .MOD(COLS)) u_col_inc (.a_i(oh_q), .b_i(CW'(1)), .y_o(oh_nx));
  wth_mod_add #(.W(RW), .MOD(ROWS)) u_row_inc (.a_i(ov_q), .b_i(RW'(1)), .y_o(ov_nx));

  // shared table index adder, wraps modulo table size
  wth_mod_add #(.W(IW), .MOD(NTAB)) u_idx_add (.a_i(op_a), .b_i(op_b), .y_o(rd_idx));

  wth_table #(.N(NTAB), .IW(IW)) u_table (
    .clk     (clk),
    .we_i    (tab_we),
    .waddr_i (tw_addr_i),
    .wdata_i (tw_data_i),
    .raddr_i (rd_idx),
    .rdata_o (rd_data)
  );

  wth_color_fold #(.W(IW), .K(HK), .KW(HW)) u_fold_h (.x_i(rd_data), .y_o(rd_h));
  wth_color_fold #(.W(IW), .K(VK), .KW(VW)) u_fold_v (.x_i(rd_data), .y_o(rd_v));

  // control decode
  assign idle   = (st_q == ST_IDLE);
  assign cap_en = idle && start_i;
  assign tab_we = idle && tw_en_i;
  assign ld_a   = (st_q == ST_RD_A);
  assign ld_b   = (st_q == ST_RD_B);
  assign ld_s   = (st_q == ST_RD_S);
  assign ld_n   = (st_q == ST_RD_N);
  assign ld_e   = (st_q == ST_RD_E);
  assign ld_w   = (st_q == ST_RD_W);
  assign done_d = ld_w;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RD_A;
      ST_RD_A: st_d = ST_RD_B;
      ST_RD_B: st_d = ST_RD_S;
      ST_RD_S: st_d = ST_RD_N;
      ST_RD_N: st_d = ST_RD_E;
      ST_RD_E: st_d = ST_RD_W;
      ST_RD_W: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // operand selection for the single table read per cycle
  always_comb begin
    op_a = '0;
    op_b = '0;
    unique case (st_q)
      ST_RD_A: begin op_a = IW'(oh_q);  op_b = '0;         end
      ST_RD_B: begin op_a = IW'(ov_q);  op_b = IW'(ov_q);  end
      ST_RD_S: begin op_a = a_q;        op_b = IW'(ov_q);  end
      ST_RD_N: begin op_a = a_q;        op_b = IW'(ov_nx); end
      ST_RD_E: begin op_a = IW'(oh_nx); op_b = b_q;        end
      ST_RD_W: begin op_a = IW'(oh_q);  op_b = b_q;        end
      default: begin op_a = '0;         op_b = '0;         end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      oh_q   <= '0;
      ov_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      s_q    <= '0;
      n_q    <= '0;
      e_q    <= '0;
      w_q    <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (cap_en) begin
        oh_q <= oh_in;
        ov_q <= ov_in;
      end
      if (ld_a) a_q <= rd_data;
      if (ld_b) b_q <= rd_data;
      if (ld_s) s_q <= rd_h;
      if (ld_n) n_q <= rd_h;
      if (ld_e) e_q <= rd_v;
      if (ld_w) w_q <= rd_v;
    end
  end

  assign done_o  = done_q;
  assign south_o = s_q;
  assign north_o = n_q;
  assign east_o  = e_q;
  assign west_o  = w_q;

  // assertions
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start_i) |-> ##7 done_o); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |=> ($stable(oh_q) && $stable(ov_q))); // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |-> ({1'b0, rd_idx} < (IW+1)'(NTAB))); // R3
  AST_COLOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((32'(south_o) < HK) && (32'(north_o) < HK) &&
                (32'(east_o) < VK) && (32'(west_o) < VK))); // R11

endmodule

// File: tb/wth_edge_hasher_tb_top.sv
module wth_edge_hasher_tb_top;
  localparam int COLS = 5;
  localparam int ROWS = 4;
  localparam int HK   = 3;
  localparam int VK   = 2;
  localparam int NT   = 5;
  localparam int IW   = 3;
  localparam int CW   = 3;
  localparam int RW   = 2;
  localparam int HW   = 2;
  localparam int VW   = 1;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [CW-1:0] col_i;
  logic [RW-1:0] row_i;
  logic          tw_en_i;
  logic [IW-1:0] tw_addr_i;
  logic [IW-1:0] tw_data_i;
  logic          done_o;
  logic [HW-1:0] south_o;
  logic [VW-1:0] east_o;
  logic [HW-1:0] north_o;
  logic [VW-1:0] west_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  int mtab [NT];
  int m_cnt = 0;
  bit m_done = 0;
  int m_oh, m_ov, m_s, m_n, m_e, m_w;
  int last_s, last_n, last_e, last_w;
  int gs [COLS][ROWS];
  int gn [COLS][ROWS];
  int ge [COLS][ROWS];
  int gw [COLS][ROWS];

  wth_edge_hasher #(.COLS(COLS), .ROWS(ROWS), .HK(HK), .VK(VK)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i), .row_i(row_i),
    .tw_en_i(tw_en_i), .tw_addr_i(tw_addr_i), .tw_data_i(tw_data_i),
    .done_o(done_o), .south_o(south_o), .east_o(east_o),
    .north_o(north_o), .west_o(west_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic calc(input int c, input int r, output int oh, output int ov,
                      output int s, output int n, output int e, output int w);
    int a, b;
    oh = c % COLS;
    ov = r % ROWS;
    a  = mtab[oh];
    b  = mtab[(2 * ov) % NT];
    s  = mtab[(a + ov) % NT] % HK;
    n  = mtab[(a + (ov + 1) % ROWS) % NT] % HK;
    e  = mtab[((oh + 1) % COLS + b) % NT] % VK;
    w  = mtab[(oh + b) % NT] % VK;
  endtask

  // cycle model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_done = 0;
    end else begin
      m_done = (m_cnt == 1);
      if (m_cnt > 0) m_cnt--;
      else begin
        if (tw_en_i && int'(tw_addr_i) < NT) mtab[tw_addr_i] = int'(tw_data_i);
        if (start_i) begin
          m_cnt = 6;
          calc(int'(col_i), int'(row_i), m_oh, m_ov, m_s, m_n, m_e, m_w);
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(done_o == m_done, "R2 done timing", int'(done_o), int'(m_done));
      if (done_o && m_done) begin
        check(int'(south_o) == m_s, "R4 south", int'(south_o), m_s);
        check(int'(north_o) == m_n, "R5 north", int'(north_o), m_n);
        check(int'(east_o)  == m_e, "R6 east",  int'(east_o),  m_e);
        check(int'(west_o)  == m_w, "R7 west",  int'(west_o),  m_w);
        check(int'(south_o) < HK && int'(north_o) < HK &&
              int'(east_o) < VK && int'(west_o) < VK, "R11 color range", 0, 0);
        gs[m_oh][m_ov] = int'(south_o);
        gn[m_oh][m_ov] = int'(north_o);
        ge[m_oh][m_ov] = int'(east_o);
        gw[m_oh][m_ov] = int'(west_o);
        last_s = int'(south_o); last_n = int'(north_o);
        last_e = int'(east_o);  last_w = int'(west_o);
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wait_idle();
    while (m_cnt != 0 || m_done) @(negedge clk);
  endtask

  task automatic issue(input int c, input int r);
    @(negedge clk);
    start_i = 1'b1;
    col_i   = CW'(c);
    row_i   = RW'(r);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic tab_write(input int addr, input int data);
    @(negedge clk);
    tw_en_i   = 1'b1;
    tw_addr_i = IW'(addr);
    tw_data_i = IW'(data);
    @(negedge clk);
    tw_en_i   = 1'b0;
  endtask

  task automatic load_table(input int mul, input int add);
    for (int i = 0; i < NT; i++) tab_write(i, (mul * i + add) % NT);
  endtask

  task automatic sweep_and_seams();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) begin
        issue(c, r);
        wait_idle();
      end
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) begin
        check(ge[c][r] == gw[(c + 1) % COLS][r], "R8 east/west seam",
              ge[c][r], gw[(c + 1) % COLS][r]);
        check(gn[c][r] == gs[c][(r + 1) % ROWS], "R8 north/south seam",
              gn[c][r], gs[c][(r + 1) % ROWS]);
      end
  endtask

  initial begin
    int es, en, ee, ew, eh, ev;
    int rs, rn, re, rw;
    rst_n = 1'b0; start_i = 1'b0; col_i = '0; row_i = '0;
    tw_en_i = 1'b0; tw_addr_i = '0; tw_data_i = '0;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done low in reset", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done low after reset", int'(done_o), 0);

    // first permutation, full sweep
    load_table(3, 2);
    sweep_and_seams();

    // wrap of out-of-range columns
    for (int c = COLS; c < (1 << CW); c++) begin
      issue(c - COLS, 1);
      wait_idle();
      rs = last_s; rn = last_n; re = last_e; rw = last_w;
      issue(c, 1);
      wait_idle();
      check(last_s == rs && last_n == rn && last_e == re && last_w == rw,
            "R3 column wrap", last_s * 8 + last_n * 4 + last_e * 2 + last_w,
            rs * 8 + rn * 4 + re * 2 + rw);
    end

    // start while busy ignored
    issue(2, 1);
    start_i = 1'b1; col_i = CW'(4); row_i = RW'(3);
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    calc(2, 1, eh, ev, es, en, ee, ew);
    check(last_s == es && last_n == en && last_e == ee && last_w == ew,
          "R9 busy start ignored", last_s * 8 + last_n * 4 + last_e * 2 + last_w,
          es * 8 + en * 4 + ee * 2 + ew);

    // write while busy dropped
    issue(1, 2);
    tw_en_i = 1'b1; tw_addr_i = IW'(0); tw_data_i = IW'(4);
    repeat (2) @(negedge clk);
    tw_en_i = 1'b0;
    wait_idle();
    check(mtab[0] == 2, "R10 model table unchanged", mtab[0], 2);
    sweep_and_seams();

    // write coinciding with start is seen by that request
    @(negedge clk);
    start_i = 1'b1; col_i = CW'(0); row_i = RW'(0);
    tw_en_i = 1'b1; tw_addr_i = IW'(0); tw_data_i = IW'(1);
    @(negedge clk);
    start_i = 1'b0; tw_en_i = 1'b0;
    wait_idle();
    calc(0, 0, eh, ev, es, en, ee, ew);
    check(last_s == es && last_w == ew, "R10 same-edge write",
          last_s * 2 + last_w, es * 2 + ew);

    // back-to-back: start in the done cycle
    issue(3, 2);
    while (!done_o) @(negedge clk);
    start_i = 1'b1; col_i = CW'(4); row_i = RW'(0);
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    calc(4, 0, eh, ev, es, en, ee, ew);
    check(last_n == en && last_e == ee, "R2 start in done cycle",
          last_n * 2 + last_e, en * 2 + ee);

    // second permutation, full sweep
    load_table(2, 1);
    sweep_and_seams();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule